// File: doc/BRIEF.md
# Converter Result I2C Target

This block is the two-wire bus target that sits in front of a converter holding a single 16-bit result. It samples the bus clock and data lines with the fast system clock and recognises START, repeated START and STOP. It compares the incoming 7-bit address with one of two fixed addresses picked by a strap input. It acknowledges only when the converter is idle. The block never drives the data line high: its only output to the line is a pull-low enable, so an external pull-up supplies the high level.

After an acknowledged read address the held result goes out most significant bit first, as two bytes. Each byte is followed by a ninth clock in which the master acknowledges. After an acknowledged write address the block takes one byte and keeps its upper four bits. These are two enable bits, a speed bit and a sleep bit, and the block applies them only when the enable bits carry the unlock pattern. A one-cycle request tells the converter sequencer to start the next conversion. It is raised when the sixteenth data bit has gone out, or when a STOP ends a transfer whose address was acknowledged.

Top module: `adcrd_i2c_target`

## Requirements
- R1: When the converter is idle and the received address matches, the block pulls the data line low for the ninth clock of the address byte. The address is 7'b0010100 with the strap low and 7'b1010100 with the strap high, and it is followed by a direction bit (1 means read).
- R2: When the address matches but the converter busy input is high, the data line stays released in the ninth clock (NAK). Nothing is applied afterwards and no conversion request is raised.
- R3: When the address does not match, the block never pulls the data line, and it waits idle for the next START.
- R4: A read returns the 16-bit result MSB first. A new bit is placed on the line after each bus-clock falling edge. The line is released during the master-acknowledge clock after each 8-bit byte.
- R5: After the falling edge that ends the sixteenth data bit, the conversion request output is high for exactly one system clock.
- R6: A STOP after an acknowledged address, arriving before the sixteenth bit completes, raises the conversion request once. A STOP after the request was already raised, or after a NAK, raises nothing.
- R7: On a write, the data byte is taken MSB first as bit7=EN1, bit6=EN2, bit5=speed and bit4=sleep, and the block acknowledges it in the ninth clock. The speed and sleep outputs take bits 5 and 4 only when bit7=1 and bit6=0; any other enable pair leaves them unchanged.
- R8: A repeated START without a STOP restarts address reception exactly like a START. A write followed by a repeated START and a full read gives the written configuration, the correct data and a single conversion request.
- R9: The pull-low enable changes only while the bus clock is low.
- R10: After reset the data line is released, the conversion request is low, and the speed and sleep outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_sel_i | input | 1 | Address strap: 0 selects 0010100, 1 selects 1010100 |
| conv_busy_i | input | 1 | High while a conversion is running |
| result_i | input | 16 | Held conversion result |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| conv_start_o | output | 1 | One-cycle request to start the next conversion |
| cfg_speed_o | output | 1 | Applied speed bit |
| cfg_sleep_o | output | 1 | Applied sleep bit |

## Verification
Two requests for the next conversion can meet near the end of a read. The completion of the sixteenth bit raises the request, and a STOP in the tail slot would raise it again if the arming were not cleared in the same edge that raises the completion request. The bench ends every full read with a master NAK and then a STOP, and counts request pulses on the port; exactly one must be seen, and the checker requires the data line to be released in the very cycle the request is high. Random transactions mix abandoned reads, writes with random enable pairs, wrong addresses and busy refusals, and a directed write then repeated START then read exercises the arming that carries across the repeated START.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_RDAT,
      ST_RACK,
      ST_WDAT,
      ST_WACK
   } adcrd_state_e;

   localparam int unsigned BYTE_BITS = 8;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/adcrd_bus_sampler.sv
module adcrd_bus_sampler #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q;
   logic              sda_q;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[0] <= 1'b1;
                  sda_ff[0] <= 1'b1;
               end else begin
                  scl_ff[0] <= scl_i;
                  sda_ff[0] <= sda_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[g] <= 1'b1;
                  sda_ff[g] <= 1'b1;
               end else begin
                  scl_ff[g] <= scl_ff[g-1];
                  sda_ff[g] <= sda_ff[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_ff[STAGES-1];
         sda_q <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/adcrd_tx_shifter.sv
module adcrd_tx_shifter #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] data,
   output logic              msb
);
   logic [DATA_W-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh <= '1;
      else if (load)  sh <= data;
      else if (shift) sh <= {sh[DATA_W-2:0], 1'b1};
   end

   assign msb = sh[DATA_W-1];
endmodule

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
   import adcrd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter logic [6:0]  ADDR_LOW  = 7'b0010100,
   parameter logic [6:0]  ADDR_HIGH = 7'b1010100,
   parameter logic [1:0]  EN_PAT    = 2'b10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_rise,
   input  logic scl_fall,
   input  logic start_det,
   input  logic stop_det,
   input  logic sda_s,
   input  logic addr_sel,
   input  logic conv_busy,
   input  logic tx_msb,
   output logic tx_load,
   output logic tx_shift,
   output logic sda_pull,
   output logic conv_start,
   output logic cfg_speed,
   output logic cfg_sleep
);
   localparam int unsigned NBYTES = DATA_W / BYTE_BITS;
   localparam int unsigned BCW    = cnt_width(NBYTES);
   localparam int unsigned BITW   = cnt_width(BYTE_BITS);
   localparam logic [BCW-1:0]  LAST_BYTE = BCW'(NBYTES - 1);
   localparam logic [BITW-1:0] LAST_BIT  = BITW'(BYTE_BITS - 1);

   adcrd_state_e    state;
   logic [BITW-1:0] bit_cnt;
   logic [BCW-1:0]  byte_cnt;
   logic [BYTE_BITS-1:0] rx_sh;
   logic            got_byte;
   logic            rw_q;
   logic            armed;
   logic            fin_q;
   logic            pulse_q;
   logic            spd_q;
   logic            slp_q;
   logic            ev_ok;
   logic [6:0]      own_addr;

   assign ev_ok    = ~start_det & ~stop_det;
   assign own_addr = addr_sel ? ADDR_HIGH : ADDR_LOW;
   assign tx_load  = ev_ok & scl_fall & (state == ST_AACK) & rw_q;
   assign tx_shift = ev_ok & scl_fall & (state == ST_RDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         rx_sh    <= '0;
         got_byte <= 1'b0;
         rw_q     <= 1'b0;
         armed    <= 1'b0;
         fin_q    <= 1'b0;
         pulse_q  <= 1'b0;
         spd_q    <= 1'b0;
         slp_q    <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (start_det) begin
            state    <= ST_ADDR;
            bit_cnt  <= '0;
            got_byte <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE;
            if (armed) begin
               pulse_q <= 1'b1;
               armed   <= 1'b0;
            end
         end else begin
            unique case (state)
               ST_IDLE: ;
               ST_ADDR, ST_WDAT: begin
                  if (scl_rise && !got_byte) begin
                     rx_sh <= {rx_sh[BYTE_BITS-2:0], sda_s};
                     if (bit_cnt == LAST_BIT) got_byte <= 1'b1;
                     else                     bit_cnt  <= bit_cnt + 1'b1;
                  end
                  if (scl_fall && got_byte) begin
                     if (state == ST_ADDR) begin
                        if ((rx_sh[7:1] == own_addr) && !conv_busy) begin
                           state <= ST_AACK;
                           rw_q  <= rx_sh[0];
                           armed <= 1'b1;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        state <= ST_WACK;
                        if (rx_sh[7:6] == EN_PAT) begin
                           spd_q <= rx_sh[5];
                           slp_q <= rx_sh[4];
                        end
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     bit_cnt  <= '0;
                     byte_cnt <= '0;
                     got_byte <= 1'b0;
                     fin_q    <= 1'b0;
                     state    <= rw_q ? ST_RDAT : ST_WDAT;
                  end
               end
               ST_RDAT: begin
                  if (scl_fall) begin
                     if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        state   <= ST_RACK;
                        if (byte_cnt == LAST_BYTE) begin
                           fin_q   <= 1'b1;
                           pulse_q <= 1'b1;
                           armed   <= 1'b0;
                        end else begin
                           byte_cnt <= byte_cnt + 1'b1;
                        end
                     end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) state <= fin_q ? ST_IDLE : ST_RDAT;
               end
               ST_WACK: begin
                  if (scl_fall) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_pull   = (state == ST_AACK) | (state == ST_WACK) |
                       ((state == ST_RDAT) & ~tx_msb);
   assign conv_start = pulse_q;
   assign cfg_speed  = spd_q;
   assign cfg_sleep  = slp_q;
endmodule

// File: rtl/adcrd_i2c_target.sv
module adcrd_i2c_target #(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [6:0]  ADDR_LOW    = 7'b0010100,
   parameter logic [6:0]  ADDR_HIGH   = 7'b1010100,
   parameter logic [1:0]  EN_PAT      = 2'b10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              addr_sel_i,
   input  logic              conv_busy_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              sda_pull_o,
   output logic              conv_start_o,
   output logic              cfg_speed_o,
   output logic              cfg_sleep_o
);
   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a nonzero multiple of 8");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_LOW == ADDR_HIGH) begin : g_bad_addr
         $error("strap addresses must differ");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic tx_load, tx_shift, tx_msb;

   adcrd_bus_sampler #(.STAGES(SYNC_STAGES)) i_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   adcrd_tx_shifter #(.DATA_W(DATA_W)) i_shifter (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tx_load),
      .shift (tx_shift),
      .data  (result_i),
      .msb   (tx_msb)
   );

   adcrd_ctrl #(
      .DATA_W    (DATA_W),
      .ADDR_LOW  (ADDR_LOW),
      .ADDR_HIGH (ADDR_HIGH),
      .EN_PAT    (EN_PAT)
   ) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .sda_s      (sda_s),
      .addr_sel   (addr_sel_i),
      .conv_busy  (conv_busy_i),
      .tx_msb     (tx_msb),
      .tx_load    (tx_load),
      .tx_shift   (tx_shift),
      .sda_pull   (sda_pull_o),
      .conv_start (conv_start_o),
      .cfg_speed  (cfg_speed_o),
      .cfg_sleep  (cfg_sleep_o)
   );

   logic unused_scl;
   assign unused_scl = scl_s;
endmodule

// File: rtl/adcrd_i2c_target_chk.sv
module adcrd_i2c_target_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_pull_o,
   input logic conv_start_o,
   input logic cfg_speed_o,
   input logic cfg_sleep_o
);
   p_pull_rise_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> !scl_i);

   p_pull_fall_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull_o) |-> !scl_i);

   p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o);

   p_start_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> !sda_pull_o);

   p_cfg_in_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cfg_speed_o) || !$stable(cfg_sleep_o)) |-> sda_pull_o);
endmodule

bind adcrd_i2c_target adcrd_i2c_target_chk i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .scl_i        (scl_i),
   .sda_pull_o   (sda_pull_o),
   .conv_start_o (conv_start_o),
   .cfg_speed_o  (cfg_speed_o),
   .cfg_sleep_o  (cfg_sleep_o)
);

// File: tb/test_adcrd_i2c_target.sv
`timescale 1ns/1ps
module test_adcrd_i2c_target;
   localparam int Q = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic addr_sel = 1'b0;
   logic busy = 1'b0;
   logic [15:0] result = '0;
   logic sda_pull, conv_start, cfg_speed, cfg_sleep;
   logic sda_line;

   int n_chk = 0, n_bad = 0, pulses = 0, edge_viol = 0;
   bit done = 0;
   logic exp_spd = 1'b0, exp_slp = 1'b0;
   logic prev_pull = 1'b0;

   always #4 clk = ~clk;
   assign sda_line = !(m_low || sda_pull);

   adcrd_i2c_target i_adcrd_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .addr_sel_i(addr_sel), .conv_busy_i(busy), .result_i(result),
      .sda_pull_o(sda_pull), .conv_start_o(conv_start),
      .cfg_speed_o(cfg_speed), .cfg_sleep_o(cfg_sleep));

   always @(posedge clk) if (rst_n && conv_start) pulses <= pulses + 1;

   always @(negedge clk) begin
      if (rst_n && (sda_pull !== prev_pull) && scl) edge_viol <= edge_viol + 1;
      prev_pull <= sda_pull;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [6:0] own(input logic sel);
      return sel ? 7'b1010100 : 7'b0010100;
   endfunction

   task automatic bus_start();
      m_low = 0; wq(Q); scl = 1; wq(Q); m_low = 1; wq(Q); scl = 0; wq(Q);
   endtask

   task automatic bus_stop();
      m_low = 1; wq(Q); scl = 1; wq(Q); m_low = 0; wq(2*Q);
   endtask

   task automatic put_bit(input logic b);
      m_low = ~b; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q);
   endtask

   task automatic get_bit(output logic b);
      m_low = 0; wq(Q); scl = 1; wq(Q); b = sda_line; wq(Q); scl = 0; wq(Q);
   endtask

   task automatic put_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
   endtask

   task automatic read_body(input logic [15:0] res, input string req);
      logic [15:0] got;
      logic b;
      for (int i = 15; i >= 8; i--) begin get_bit(b); got[i] = b; end
      put_bit(1'b0);
      for (int i = 7; i >= 0; i--) begin get_bit(b); got[i] = b; end
      put_bit(1'b1);
      check(req, got, res);
   endtask

   // Read transaction; full=0 stops right after the address acknowledge.
   task automatic xfer_read(input logic [6:0] a, input logic bz, input logic [15:0] res,
                            input bit full);
      logic ack;
      bit acked;
      int p0;
      busy = bz; result = res; p0 = pulses;
      bus_start();
      put_byte({a, 1'b1});
      get_bit(ack);
      acked = (a == own(addr_sel)) && !bz;
      check(acked ? "R1 address ack" : (bz ? "R2 busy nak" : "R3 mismatch nak"),
            ack, acked ? 0 : 1);
      if (acked && full) read_body(res, "R4 read data");
      bus_stop();
      wq(4);
      check(full && acked ? "R5 completion pulse" : "R6 stop pulse",
            pulses - p0, acked ? 1 : 0);
      busy = 0;
   endtask

   task automatic xfer_write(input logic [6:0] a, input logic bz, input logic [3:0] nib,
                             input bit sr_read, input logic [15:0] res);
      logic ack;
      bit acked;
      int p0;
      busy = bz; result = res; p0 = pulses;
      bus_start();
      put_byte({a, 1'b0});
      get_bit(ack);
      acked = (a == own(addr_sel)) && !bz;
      check(acked ? "R1 write address ack" : "R2 write refused", ack, acked ? 0 : 1);
      if (acked) begin
         put_byte({nib, 4'b1111});
         get_bit(ack);
         check("R7 config byte ack", ack, 0);
         if (nib[3:2] == 2'b10) begin exp_spd = nib[1]; exp_slp = nib[0]; end
      end
      if (sr_read && acked) begin
         bus_start();
         put_byte({a, 1'b1});
         get_bit(ack);
         check("R8 repeated start ack", ack, 0);
         read_body(res, "R8 read after repeated start");
      end
      bus_stop();
      wq(4);
      check("R7 speed bit", cfg_speed, exp_spd);
      check("R7 sleep bit", cfg_sleep, exp_slp);
      check(sr_read ? "R8 single pulse" : "R6 write stop pulse", pulses - p0, acked ? 1 : 0);
      busy = 0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      wq(5);
      check("R10 pull released", sda_pull, 0);
      check("R10 no request", conv_start, 0);
      check("R10 speed", cfg_speed, 0);
      check("R10 sleep", cfg_sleep, 0);
      rst_n = 1; wq(10);

      // directed corners
      addr_sel = 0; xfer_read(7'b0010100, 0, 16'hA5C3, 1);
      addr_sel = 1; xfer_read(7'b1010100, 0, 16'h0001, 1);
      xfer_read(7'b1010100, 0, 16'hFFFE, 1);
      xfer_read(7'b0010100, 0, 16'h1234, 1);
      xfer_read(7'b1010100, 1, 16'h5555, 1);
      xfer_read(7'b1010100, 0, 16'h8000, 0);
      xfer_write(7'b1010100, 0, 4'b1011, 0, 16'h0);
      xfer_write(7'b1010100, 0, 4'b1100, 0, 16'h0);
      xfer_write(7'b1010100, 0, 4'b0000, 0, 16'h0);
      xfer_write(7'b1010100, 1, 4'b1000, 0, 16'h0);
      addr_sel = 0;
      xfer_write(7'b0010100, 0, 4'b1001, 1, 16'h7E81);
      check("R9 pull edges with clock low", edge_viol, 0);

      // random mix
      for (int t = 0; t < 24; t++) begin
         int kind;
         logic [6:0] a;
         logic bz;
         logic [15:0] r;
         kind = $urandom % 4;
         addr_sel = $urandom % 2;
         bz = ($urandom % 4) == 0;
         r = 16'($urandom);
         a = (kind == 3) ? own(~addr_sel) : own(addr_sel);
         case (kind)
            0: xfer_read(a, bz, r, 1);
            1: xfer_read(a, bz, r | 16'h8000, 0);
            2: xfer_write(a, bz, 4'($urandom), ($urandom % 2) == 1, r);
            default: xfer_read(a, 0, r, 1);
         endcase
      end
      check("R9 pull edges with clock low", edge_viol, 0);

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule